// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block drives the transmission gates of an eight-queue Ethernet egress port from a repeating timetable. Synchronized time is an input: a free-running 64-bit nanosecond count. From a programmed first-cycle start time onward, the block splits that time into cycles of fixed programmable length. Inside each cycle it steps through a list of slices. Each slice has a duration in nanoseconds and an 8-bit mask that says which queues are open. Every cycle begins again from the first slice.

The block has two outputs. The first is the open/closed gate vector. The second is a per-queue permission to begin a new frame. The permission is withheld in a guard band: the window before a slice boundary at which that queue's gate is about to close. This keeps a frame that starts late from running into the next slice. The guard band has a full-frame length and a shorter fragment length, and an input picks between them for links that cut frames. Only new frame starts are gated, so a frame already on the wire is never stopped here. Software writes a shadow copy of the timetable and then requests a commit. The copy becomes active only at the next cycle start.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and until the sampled time first reaches `base_time_i`, `gate_o` and `start_ok_o` are both all zeros.
- R2: Cycle k begins when the sampled time reaches base + k × cycle length. At every cycle start, the schedule returns to its first slice.
- R3: `gate_o` equals the mask of the slice in which the elapsed cycle time lies. Slice i covers elapsed times from the sum of durations 0..i-1 up to, but not including, the sum of durations 0..i. The output changes just after the clock edge at which the sampled time first lies in the new slice. Bit q of a mask is queue q.
- R4: When the slice durations add up to less than the cycle length, the last slice's mask holds until the cycle ends.
- R5: When the slice durations add up to more than the cycle length, the schedule is cut off at the cycle end. Any slice still pending is skipped.
- R6: `start_ok_o[q]` is 1 only when `gate_o[q]` is 1. It is forced to 0 when two conditions hold together: queue q is closed in the slice that comes next (this is the first slice of the next cycle when the current slice reaches the cycle end), and the time left to that boundary is smaller than the guard length.
- R7: The guard length is `guard_full_i` when `preempt_en_i` is 0 and `guard_frag_i` when it is 1. A shorter fragment guard therefore allows starts closer to the boundary.
- R8: A queue that is open in both the current slice and the next slice keeps its start permission inside the guard band.
- R9: Entry writes, header writes and commits do not change the running schedule. The shadow copy becomes active at the first cycle start at or after a commit. A commit on the very clock of a cycle start takes effect at that start.
- R10: An active schedule with zero entries keeps all gates and all start permissions closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Synchronized time in ns |
| base_time_i | input | 64 | Start time of the first cycle |
| preempt_en_i | input | 1 | Selects the fragment guard length |
| guard_full_i | input | 32 | Guard length without preemption, ns |
| guard_frag_i | input | 32 | Guard length with preemption, ns |
| cfg_ent_we_i | input | 1 | Shadow entry write strobe |
| cfg_ent_addr_i | input | 4 | Shadow entry index |
| cfg_ent_dur_i | input | 32 | Slice duration, ns |
| cfg_ent_mask_i | input | 8 | Slice gate mask |
| cfg_hdr_we_i | input | 1 | Shadow header write strobe |
| cfg_hdr_cnt_i | input | 5 | Number of slices (clamped to 16) |
| cfg_hdr_len_i | input | 32 | Cycle length, ns |
| cfg_commit_i | input | 1 | Request shadow-to-active copy at next cycle start |
| gate_o | output | 8 | Current gate state per queue |
| start_ok_o | output | 8 | Permission to begin a new frame per queue |

## Verification
Two kinds of event can land on the same clock edge. One is a cycle restart that cuts off a slice list longer than the cycle. The other is a staged commit. The bench raises the commit pulse on the exact clock at which its own model predicts the cycle boundary. It then checks that the new list starts from its first slice at that boundary, and that the guard band in front of the cut-off used the first slice of the next cycle as the following mask. A behavioural model compares both output vectors on every clock. Spot checks at chosen times cover the guard band with and without the fragment length.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int unsigned TAS_NQ   = 8;
  localparam int unsigned TAS_NENT = 16;
  localparam int unsigned TAS_DW   = 32;
  localparam int unsigned TAS_TW   = 64;
endpackage

// File: rtl/tas_sched_regs.sv
module tas_sched_regs #(
  parameter int unsigned NQ   = 8,
  parameter int unsigned NENT = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_dur_i,
  input  logic [NQ-1:0]            wr_mask_i,
  input  logic                     hdr_en_i,
  input  logic [CW-1:0]            hdr_cnt_i,
  input  logic [DW-1:0]            hdr_len_i,
  input  logic                     commit_i,
  input  logic                     load_i,
  output logic [NENT-1:0][DW-1:0]  act_dur_o,
  output logic [NENT-1:0][NQ-1:0]  act_mask_o,
  output logic [CW-1:0]            act_cnt_o,
  output logic [DW-1:0]            act_len_o,
  output logic [DW-1:0]            nxt_dur0_o
);
  logic [NENT-1:0][DW-1:0] sh_dur_q;
  logic [NENT-1:0][NQ-1:0] sh_mask_q;
  logic [CW-1:0]           sh_cnt_q;
  logic [DW-1:0]           sh_len_q;
  logic                    pend_q;
  logic                    do_load;

  assign do_load    = load_i && (pend_q || commit_i);
  assign nxt_dur0_o = do_load ? sh_dur_q[0] : act_dur_o[0];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_dur_q[g]   <= '0;
        sh_mask_q[g]  <= '0;
        act_dur_o[g]  <= '0;
        act_mask_o[g] <= '0;
      end else begin
        if (wr_en_i && (wr_addr_i == AW'(g))) begin
          sh_dur_q[g]  <= wr_dur_i;
          sh_mask_q[g] <= wr_mask_i;
        end
        if (do_load) begin
          act_dur_o[g]  <= sh_dur_q[g];
          act_mask_o[g] <= sh_mask_q[g];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cnt_q  <= '0;
      sh_len_q  <= '0;
      act_cnt_o <= '0;
      act_len_o <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (hdr_en_i) begin
        sh_cnt_q <= (hdr_cnt_i > CW'(NENT)) ? CW'(NENT) : hdr_cnt_i;
        sh_len_q <= hdr_len_i;
      end
      if (do_load) begin
        act_cnt_o <= sh_cnt_q;
        act_len_o <= sh_len_q;
        pend_q    <= 1'b0;
      end else if (commit_i) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tas_cycle_timer.sv
module tas_cycle_timer #(
  parameter int unsigned TW = 64,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] base_i,
  input  logic [DW-1:0] len_i,
  output logic          run_o,
  output logic          new_cyc_o,
  output logic [DW-1:0] el_now_o,
  output logic [DW-1:0] el_q_o
);
  logic [TW-1:0] cs_q, cs_nxt, diff, el_full;
  logic          start_c, bnd_c;

  always_comb begin
    diff    = time_i - cs_q;
    start_c = !run_o && (time_i >= base_i);
    bnd_c   = run_o && (diff >= TW'(len_i));
    cs_nxt  = cs_q;
    el_full = diff;
    if (start_c) begin
      cs_nxt  = base_i;
      el_full = time_i - base_i;
    end else if (bnd_c) begin
      cs_nxt  = cs_q + TW'(len_i);
      el_full = diff - TW'(len_i);
    end
  end

  assign new_cyc_o = start_c || bnd_c;
  assign el_now_o  = diff[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      cs_q   <= '0;
      el_q_o <= '0;
    end else begin
      if (start_c) run_o <= 1'b1;
      cs_q <= cs_nxt;
      if (run_o || start_c) el_q_o <= el_full[DW-1:0];
    end
  end
endmodule

// File: rtl/tas_slice_walker.sv
module tas_slice_walker #(
  parameter int unsigned NENT = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1),
  localparam int unsigned SW  = DW + AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    new_cyc_i,
  input  logic [DW-1:0]           el_now_i,
  input  logic [CW-1:0]           act_cnt_i,
  input  logic [NENT-1:0][DW-1:0] act_dur_i,
  input  logic [DW-1:0]           nxt_dur0_i,
  output logic [AW-1:0]           idx_o,
  output logic [SW-1:0]           seg_end_o
);
  logic [AW-1:0] idx_inc;
  logic          has_next, reached;

  assign idx_inc  = idx_o + AW'(1);
  assign has_next = (CW'(idx_o) + CW'(1)) < act_cnt_i;
  assign reached  = SW'(el_now_i) >= seg_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      seg_end_o <= '0;
    end else if (new_cyc_i) begin
      idx_o     <= '0;
      seg_end_o <= SW'(nxt_dur0_i);
    end else if (run_i && has_next && reached) begin
      idx_o     <= idx_inc;
      seg_end_o <= seg_end_o + SW'(act_dur_i[idx_inc]);
    end
  end
endmodule

// File: rtl/tas_guard_gate.sv
module tas_guard_gate #(
  parameter int unsigned NQ   = 8,
  parameter int unsigned NENT = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1),
  localparam int unsigned SW  = DW + AW
) (
  input  logic                    run_i,
  input  logic [CW-1:0]           act_cnt_i,
  input  logic [DW-1:0]           act_len_i,
  input  logic [NENT-1:0][NQ-1:0] act_mask_i,
  input  logic [AW-1:0]           idx_i,
  input  logic [SW-1:0]           seg_end_i,
  input  logic [DW-1:0]           el_q_i,
  input  logic [DW-1:0]           glen_i,
  output logic [NQ-1:0]           gate_o,
  output logic [NQ-1:0]           start_ok_o
);
  logic          live, mid, in_guard;
  logic [SW-1:0] bound, rem;
  logic [NQ-1:0] nmask, closing;
  logic [AW-1:0] idx_inc;

  always_comb begin
    idx_inc  = idx_i + AW'(1);
    live     = run_i && (act_cnt_i != '0);
    // boundary ahead is a slice edge inside the cycle, else the cycle end
    mid      = ((CW'(idx_i) + CW'(1)) < act_cnt_i) && (seg_end_i < SW'(act_len_i));
    bound    = mid ? seg_end_i : SW'(act_len_i);
    nmask    = mid ? act_mask_i[idx_inc] : act_mask_i[0];
    rem      = bound - SW'(el_q_i);
    in_guard = rem < SW'(glen_i);
    gate_o   = live ? act_mask_i[idx_i] : '0;
    closing  = gate_o & ~nmask;
    start_ok_o = in_guard ? (gate_o & ~closing) : gate_o;
  end
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int unsigned NQ   = TAS_NQ,
  parameter int unsigned NENT = TAS_NENT,
  parameter int unsigned DW   = TAS_DW,
  parameter int unsigned TW   = TAS_TW,
  localparam int unsigned AW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1),
  localparam int unsigned SW  = DW + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] base_time_i,
  input  logic          preempt_en_i,
  input  logic [DW-1:0] guard_full_i,
  input  logic [DW-1:0] guard_frag_i,
  input  logic          cfg_ent_we_i,
  input  logic [AW-1:0] cfg_ent_addr_i,
  input  logic [DW-1:0] cfg_ent_dur_i,
  input  logic [NQ-1:0] cfg_ent_mask_i,
  input  logic          cfg_hdr_we_i,
  input  logic [CW-1:0] cfg_hdr_cnt_i,
  input  logic [DW-1:0] cfg_hdr_len_i,
  input  logic          cfg_commit_i,
  output logic [NQ-1:0] gate_o,
  output logic [NQ-1:0] start_ok_o
);
  logic                    run, new_cyc;
  logic [DW-1:0]           el_now, el_q, act_len, nxt_dur0, glen;
  logic [NENT-1:0][DW-1:0] act_dur;
  logic [NENT-1:0][NQ-1:0] act_mask;
  logic [CW-1:0]           act_cnt;
  logic [AW-1:0]           idx;
  logic [SW-1:0]           seg_end;

  assign glen = preempt_en_i ? guard_frag_i : guard_full_i;

  tas_sched_regs #(.NQ(NQ), .NENT(NENT), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(cfg_ent_we_i), .wr_addr_i(cfg_ent_addr_i),
    .wr_dur_i(cfg_ent_dur_i), .wr_mask_i(cfg_ent_mask_i),
    .hdr_en_i(cfg_hdr_we_i), .hdr_cnt_i(cfg_hdr_cnt_i), .hdr_len_i(cfg_hdr_len_i),
    .commit_i(cfg_commit_i), .load_i(new_cyc),
    .act_dur_o(act_dur), .act_mask_o(act_mask), .act_cnt_o(act_cnt),
    .act_len_o(act_len), .nxt_dur0_o(nxt_dur0)
  );

  tas_cycle_timer #(.TW(TW), .DW(DW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i), .base_i(base_time_i),
    .len_i(act_len), .run_o(run), .new_cyc_o(new_cyc),
    .el_now_o(el_now), .el_q_o(el_q)
  );

  tas_slice_walker #(.NENT(NENT), .DW(DW)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .new_cyc_i(new_cyc),
    .el_now_i(el_now), .act_cnt_i(act_cnt), .act_dur_i(act_dur),
    .nxt_dur0_i(nxt_dur0), .idx_o(idx), .seg_end_o(seg_end)
  );

  tas_guard_gate #(.NQ(NQ), .NENT(NENT), .DW(DW)) u_guard (
    .run_i(run), .act_cnt_i(act_cnt), .act_len_i(act_len), .act_mask_i(act_mask),
    .idx_i(idx), .seg_end_i(seg_end), .el_q_i(el_q), .glen_i(glen),
    .gate_o(gate_o), .start_ok_o(start_ok_o)
  );
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
  parameter int unsigned NQ   = 8,
  parameter int unsigned NENT = 16,
  parameter int unsigned DW   = 32,
  localparam int unsigned AW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          new_cyc_i,
  input logic [DW-1:0] el_q_i,
  input logic [DW-1:0] act_len_i,
  input logic [CW-1:0] act_cnt_i,
  input logic [AW-1:0] idx_i,
  input logic [NQ-1:0] gate_i,
  input logic [NQ-1:0] start_ok_i
);
  p_idle_closed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (gate_i == '0) && (start_ok_i == '0));

  p_restart_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_cyc_i |=> (idx_i == '0));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (act_cnt_i != '0)) |-> (CW'(idx_i) < act_cnt_i));

  p_el_in_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (act_len_i != '0)) |-> (el_q_i < act_len_i));

  p_start_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok_i & ~gate_i) == '0);

  p_table_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_cyc_i |=> $stable(act_cnt_i) && $stable(act_len_i));

  p_empty_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_cnt_i == '0) |-> (gate_i == '0));
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.NQ(NQ), .NENT(NENT), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .new_cyc_i(new_cyc),
  .el_q_i(el_q), .act_len_i(act_len), .act_cnt_i(act_cnt), .idx_i(idx),
  .gate_i(gate_o), .start_ok_i(start_ok_o)
);

// File: tb/tas_gate_sched_tb.sv
`timescale 1ns/1ps
module tas_gate_sched_tb;
  localparam int STEP = 4;

  logic        clk = 0, rst_n = 0;
  logic [63:0] time_v = 0;
  logic [63:0] base_v = 64'd1000;
  logic        pre_en = 0;
  logic [31:0] g_full = 32'd120, g_frag = 32'd40;
  logic        e_we = 0, h_we = 0, commit = 0;
  logic [3:0]  e_addr = 0;
  logic [31:0] e_dur = 0, h_len = 0;
  logic [7:0]  e_mask = 0;
  logic [4:0]  h_cnt = 0;
  logic [7:0]  gate, start_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tas_gate_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_v), .base_time_i(base_v),
    .preempt_en_i(pre_en), .guard_full_i(g_full), .guard_frag_i(g_frag),
    .cfg_ent_we_i(e_we), .cfg_ent_addr_i(e_addr), .cfg_ent_dur_i(e_dur),
    .cfg_ent_mask_i(e_mask), .cfg_hdr_we_i(h_we), .cfg_hdr_cnt_i(h_cnt),
    .cfg_hdr_len_i(h_len), .cfg_commit_i(commit),
    .gate_o(gate), .start_ok_o(start_ok)
  );

  always #2.5 clk = ~clk;

  // reference model
  longint ts = 0, mcs = 0;
  bit     mrun = 0, mpend = 0;
  int     sh_dur[16], sh_mask[16], ac_dur[16], ac_mask[16];
  int     sh_cnt = 0, sh_len = 0, ac_cnt = 0, ac_len = 0;
  logic [7:0] x_gate = 0, x_start = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit newc;
      newc = 0;
      ts = longint'(time_v);
      if (!mrun) begin
        if (ts >= longint'(base_v)) begin mrun = 1; mcs = longint'(base_v); newc = 1; end
      end else if (ts - mcs >= longint'(ac_len)) begin
        mcs = mcs + ac_len; newc = 1;
      end
      if (newc && (mpend || commit)) begin
        for (int i = 0; i < 16; i++) begin ac_dur[i] = sh_dur[i]; ac_mask[i] = sh_mask[i]; end
        ac_cnt = sh_cnt; ac_len = sh_len; mpend = 0;
      end else if (commit) mpend = 1;
      if (e_we) begin sh_dur[e_addr] = int'(e_dur); sh_mask[e_addr] = int'(e_mask); end
      if (h_we) begin sh_cnt = (h_cnt > 16) ? 16 : int'(h_cnt); sh_len = int'(h_len); end
      if (!mrun || ac_cnt == 0) begin
        x_gate = 0; x_start = 0;
      end else begin
        longint el, sum, send, bnd, gl;
        int idx, nm;
        bit found, mid;
        el = ts - mcs; sum = 0; idx = ac_cnt - 1; found = 0; send = 0;
        for (int i = 0; i < ac_cnt; i++) begin
          sum += ac_dur[i];
          if (!found && el < sum) begin idx = i; send = sum; found = 1; end
        end
        if (!found) send = sum;
        mid = (idx < ac_cnt - 1) && (send < ac_len);
        bnd = mid ? send : ac_len;
        nm  = mid ? ac_mask[idx+1] : ac_mask[0];
        gl  = pre_en ? longint'(g_frag) : longint'(g_full);
        x_gate = 8'(ac_mask[idx]);
        x_start = (bnd - el < gl) ? (x_gate & 8'(nm)) : x_gate;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%02h expected=%02h", req, ts, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin sh_dur[i] = 0; sh_mask[i] = 0; ac_dur[i] = 0; ac_mask[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset gate", gate, 8'h00);
    chk("R1 reset start", start_ok, 8'h00);
    rst_n = 1;
    forever begin
      longint tn;
      @(negedge clk);
      // every-clock comparison with the model
      chk("R3 gate", gate, x_gate);
      chk("R6 start", start_ok, x_start);
      case (ts)
        996:  chk("R1 before base", gate, 8'h00);
        1052: chk("R6 far from edge", start_ok, 8'h01);
        1100: begin chk("R3 slice0", gate, 8'h01); chk("R6 guard", start_ok, 8'h00); end
        1300: chk("R3 slice1", gate, 8'h06);
        1452: chk("R8 stays open", start_ok, 8'h04);
        1800: begin chk("R4 last holds", gate, 8'hF4); chk("R4 start", start_ok, 8'hF4); end
        1952: chk("R6 cycle-end guard", start_ok, 8'h00);
        2452: chk("R7 frag guard", start_ok, 8'h06);
        2472: chk("R7 frag guard inside", start_ok, 8'h04);
        2952: chk("R7 frag guard at end", start_ok, 8'hF4);
        3100: chk("R2 restart", gate, 8'h01);
        3700: chk("R9 staged unused", gate, 8'hF4);
        4000: begin chk("R9 commit on boundary", gate, 8'h0F); chk("R9 start", start_ok, 8'h0F); end
        4952: begin chk("R5 cut slice", gate, 8'hFF); chk("R5 guard to first", start_ok, 8'h0F); end
        5020: chk("R5 restart after cut", gate, 8'h0F);
        5500: chk("R9 pending not yet", gate, 8'h81);
        6100: begin chk("R10 empty gate", gate, 8'h00); chk("R10 empty start", start_ok, 8'h00); end
        default: ;
      endcase
      if (ts >= 6400) begin done = 1; finish_run(); end
      // drive next inputs
      time_v = time_v + STEP;
      tn = longint'(time_v);
      e_we = 0; h_we = 0; commit = 0;
      pre_en = (tn >= 2000 && tn < 3000);
      case (tn)
        8:  begin e_we = 1; e_addr = 0; e_dur = 200; e_mask = 8'h01; end
        12: begin e_we = 1; e_addr = 1; e_dur = 300; e_mask = 8'h06; end
        16: begin e_we = 1; e_addr = 2; e_dur = 150; e_mask = 8'hF4; end
        20: begin h_we = 1; h_cnt = 3; h_len = 1000; end
        24: commit = 1;
        3200: begin e_we = 1; e_addr = 0; e_dur = 300; e_mask = 8'h0F; end
        3204: begin e_we = 1; e_addr = 1; e_dur = 300; e_mask = 8'h81; end
        3208: begin e_we = 1; e_addr = 2; e_dur = 500; e_mask = 8'hFF; end
        3212: begin e_we = 1; e_addr = 3; e_dur = 300; e_mask = 8'h10; end
        3216: begin h_we = 1; h_cnt = 4; h_len = 1000; end
        5300: begin h_we = 1; h_cnt = 0; h_len = 1000; end
        5304: commit = 1;
        default: ;
      endcase
      // commit lands on the boundary clock itself
      if (tn >= 3900 && tn < 4100 && mrun && (tn - mcs >= longint'(ac_len))) commit = 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end
endmodule